// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial EEPROM. It sits on a fast system clock and watches the SCL and SDA bus lines through synchronisers. It drives SDA only through an active-high pull-low enable. A master addresses it with a select byte. For a write, the master then sends a two-byte word address and data. For a read, the block returns bytes from an internal register array.

Writes are collected in a page buffer the size of one page. The array is updated in a single clock only when a STOP closes the write. A write-control input, held high, makes the block refuse data bytes. Reads can start at the current internal address, or at an address loaded first by a dummy write followed by a repeated START. A read keeps streaming bytes for as long as the master acknowledges them.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The first byte after START is a select byte, sent most significant bit first. It matches when bits 7..4 are 1010, bit 3 is 0 and bits 2..1 equal `chipEn`. Bit 0 selects read (1) or write (0). On a match the block pulls SDA low during the ninth SCL pulse. On a mismatch it leaves SDA released and ignores every later byte until the next START.
- R2: SDA is sampled on the synchronised SCL rising edge. `sdaOe` changes only while SCL is low, after a detected SCL falling edge.
- R3: After a write select, the next two bytes are the address high byte and then the address low byte, and both are acknowledged. Bit 15 and every bit above the array width are ignored; with the default array of 512 bytes the low 9 bits are kept.
- R4: Each data byte of a write that is acknowledged is buffered at the page offset given by the low 6 bits of the address counter. Only those 6 bits advance, wrapping within the 64-byte page, so a later byte replaces an earlier one at the same offset. The buffered bytes reach the array when a STOP arrives.
- R5: Buffered write data that is ended by a repeated START instead of a STOP is discarded, and the array keeps its old contents.
- R6: While `wrCtl` is high, data bytes are neither acknowledged nor stored. Address bytes are still acknowledged and still load the address counter.
- R7: A random read works as follows. The master sends a write select and two address bytes, then a repeated START and a read select. The block then returns the byte at the loaded address.
- R8: A read select with no preceding address phase returns the byte at the current address counter. That is the address one past the last byte read or buffered.
- R9: While the master acknowledges each read byte, the block sends the next one. The address wraps from the top of the array to zero.
- R10: When the master does not acknowledge a read byte, the block releases SDA and stays released on later SCL pulses until a START.
- R11: After reset the block holds SDA released, the array reads as zero and the address counter is zero.
- R12: A START or STOP condition releases SDA within one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level, as resolved on the bus |
| chipEn | input | 2 | Chip-enable pattern compared with select bits 2..1 |
| wrCtl | input | 1 | Write control; high blocks data writes |
| sdaOe | output | 1 | High pulls SDA low |

## Verification
The assertions assume the master keeps each SCL level for longer than the synchroniser latency. They also assume it never forms a START or STOP while the slave is pulling SDA low. Under those conditions, every change of the drive enable must land in an SCL-low window, and a START or STOP must leave the line released. The stimulus holds every SCL phase for six clocks. It issues START and STOP only after an acknowledge slot has ended or a read has been refused. It changes `wrCtl` and `chipEn` only between transactions.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADRH, ST_ADRL, ST_WDAT, ST_RDAT
  } state_t;

  typedef struct packed {
    logic shiftIn;   // capture one SDA bit
    logic loadHi;    // address high byte complete
    logic loadLo;    // address low byte complete
    logic bufPut;    // store received byte in page buffer
    logic bufDrop;   // discard buffered page data
    logic commit;    // STOP seen during a write
    logic loadTx;    // fetch array byte for transmission
    logic shiftTx;   // present next transmit bit
    logic stepRead;  // advance address after a read byte
  } strobe_t;
endpackage

// File: rtl/eeprom_i2c_ctrl.sv
module eeprom_i2c_ctrl
  import eeprom_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaS,
  input  logic [7:0] rxByte,
  input  logic [1:0] chipEn,
  input  logic       wrCtl,
  output strobe_t    stb,
  output logic       ackDrive,
  output logic       txActive
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  state_t     state;
  logic [3:0] bitCnt;
  logic       mAck;
  logic       receiving;
  logic       devMatch;

  assign receiving = state inside {ST_DEV, ST_ADRH, ST_ADRL, ST_WDAT};
  assign devMatch  = (rxByte[7:4] == TYPE_CODE) && !rxByte[3] && (rxByte[2:1] == chipEn);

  always_comb begin
    stb = '0;
    if (startDet) begin
      stb.bufDrop = 1'b1;
    end else if (stopDet) begin
      stb.commit = (state == ST_WDAT);
    end else if (state != ST_IDLE) begin
      if (sclRise && receiving && bitCnt < LAST_BIT) stb.shiftIn = 1'b1;
      if (sclFall) begin
        if (bitCnt == LAST_BIT) begin
          case (state)
            ST_ADRH: stb.loadHi   = 1'b1;
            ST_ADRL: stb.loadLo   = 1'b1;
            ST_WDAT: stb.bufPut   = !wrCtl;
            ST_RDAT: stb.stepRead = 1'b1;
            default: ;
          endcase
        end else if (bitCnt == ACK_BIT) begin
          stb.loadTx = (state == ST_RDAT) && mAck;
        end else if (bitCnt != 4'd0 && state == ST_RDAT) begin
          stb.shiftTx = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      mAck     <= 1'b0;
    end else if (startDet) begin
      state    <= ST_DEV;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < ACK_BIT) bitCnt <= bitCnt + 4'd1;
        if (bitCnt == LAST_BIT) mAck <= !sdaS;
      end
      if (sclFall) begin
        if (bitCnt == LAST_BIT) begin
          case (state)
            ST_DEV: begin
              if (devMatch) begin
                ackDrive <= 1'b1;
                state    <= rxByte[0] ? ST_RDAT : ST_ADRH;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_ADRH: begin ackDrive <= 1'b1; state <= ST_ADRL; end
            ST_ADRL: begin ackDrive <= 1'b1; state <= ST_WDAT; end
            ST_WDAT: ackDrive <= !wrCtl;
            ST_RDAT: txActive <= 1'b0;
            default: ;
          endcase
        end else if (bitCnt == ACK_BIT) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          if (state == ST_RDAT) begin
            if (mAck) txActive <= 1'b1;
            else      state    <= ST_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_data.sv
module eeprom_i2c_data
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic       sdaS,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       memWe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - 8;

  logic [7:0]        mem     [DEPTH];
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   pageMask;
  logic [ADDR_W-1:0] addr;
  logic [HI_W-1:0]   addrHi;
  logic [7:0]        rxSh;
  logic [7:0]        txSh;
  logic [ADDR_W-PAGE_W-1:0] pageBase;

  assign rxByte   = rxSh;
  assign txBit    = txSh[7];
  assign memWe    = stb.commit && (|pageMask);
  assign pageBase = addr[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh     <= '0;
      txSh     <= '1;
      addr     <= '0;
      addrHi   <= '0;
      pageMask <= '0;
    end else begin
      if (stb.shiftIn) rxSh <= {rxSh[6:0], sdaS};
      if (stb.loadHi)  addrHi <= rxSh[HI_W-1:0];
      if (stb.loadLo)  addr <= {addrHi, rxSh};
      if (stb.bufPut) begin
        pageMask[addr[PAGE_W-1:0]] <= 1'b1;
        addr <= {pageBase, addr[PAGE_W-1:0] + 1'b1};
      end
      if (stb.stepRead) addr <= addr + 1'b1;
      if (stb.loadTx)   txSh <= mem[addr];
      if (stb.shiftTx)  txSh <= {txSh[6:0], 1'b1};
      if (stb.bufDrop || stb.commit) pageMask <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufPut) pageBuf[addr[PAGE_W-1:0]] <= rxSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (memWe) begin
      for (int j = 0; j < PAGE; j++)
        if (pageMask[j]) mem[{pageBase, PAGE_W'(j)}] <= pageBuf[j];
    end
  end
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] chipEn,
  input  logic       wrCtl,
  output logic       sdaOe
);
  logic [1:0] rawIn, lineS, linePrev;
  logic       sclS, sdaS, sclPrev, sdaPrev;
  logic       sclRise, sclFall, startDet, stopDet;
  logic       ackDrive, txActive, txBit, memWe;
  logic [7:0] rxByte;
  strobe_t    stb;

  assign rawIn = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign lineS[g] = pipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= '1;
    else       linePrev <= lineS;
  end

  assign sclS     = lineS[0];
  assign sdaS     = lineS[1];
  assign sclPrev  = linePrev[0];
  assign sdaPrev  = linePrev[1];
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;

  eeprom_i2c_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .rxByte(rxByte),
    .chipEn(chipEn), .wrCtl(wrCtl), .stb(stb), .ackDrive(ackDrive),
    .txActive(txActive)
  );

  eeprom_i2c_data #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaS), .rxByte(rxByte),
    .txBit(txBit), .memWe(memWe)
  );

  assign sdaOe = ackDrive | (txActive & ~txBit);
endmodule

// File: rtl/eeprom_i2c_chk.sv
module eeprom_i2c_chk (
  input logic clk,
  input logic rstN,
  input logic sclS,
  input logic startDet,
  input logic stopDet,
  input logic sdaOe,
  input logic ackDrive,
  input logic txActive,
  input logic memWe
);
  AST_ACK_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrive && txActive)); // R1

  AST_DRIVE_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(startDet) && !$past(stopDet)) |-> !sclS); // R2

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe); // R12

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R12

  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> stopDet); // R4
endmodule

bind eeprom_i2c_slave eeprom_i2c_chk u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startDet(startDet), .stopDet(stopDet),
  .sdaOe(sdaOe), .ackDrive(ackDrive), .txActive(txActive), .memWe(memWe)
);

// File: tb/eeprom_i2c_slave_test.sv
module eeprom_i2c_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic mLow = 1'b0;
  logic [1:0] chipEnB = 2'b10;
  logic wrCtlB = 1'b0;
  logic sdaOe;
  logic sdaLine;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] refMem [512];
  logic [8:0] refAddr = '0;
  logic [7:0] wdat [80];

  assign sdaLine = !mLow && !sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_i2c_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .chipEn(chipEnB), .wrCtl(wrCtlB), .sdaOe(sdaOe)
  );

  // R2 monitor: drive enable must not move while SCL is held high
  logic oePrev = 1'b0;
  logic sclPrevB = 1'b1;
  int drvViol = 0;
  always @(negedge clk) begin
    if (rstN && sclM && sclPrevB && (sdaOe != oePrev)) drvViol++;
    oePrev = sdaOe;
    sclPrevB = sclM;
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input bit rw);
    return {4'b1010, 1'b0, chipEnB, rw};
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic putBit(input logic b);
    mLow = !b; waitQ(); sclM = 1'b1; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    mLow = 1'b0; waitQ(); sclM = 1'b1; waitQ(); ack = !sdaLine; sclM = 1'b0; waitQ();
  endtask

  task automatic getByte(input logic ackIt, output logic [7:0] b);
    mLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sclM = 1'b1; waitQ(); b[i] = sdaLine; sclM = 1'b0;
    end
    waitQ(); mLow = ackIt; waitQ(); sclM = 1'b1; waitQ(); sclM = 1'b0; waitQ(); mLow = 1'b0;
  endtask

  task automatic busStart();
    mLow = 1'b0; waitQ(); sclM = 1'b1; waitQ(); mLow = 1'b1; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop(input bool_chk);
    mLow = 1'b1; waitQ(); sclM = 1'b1; waitQ(); mLow = 1'b0; waitQ();
    if (bool_chk) check("R12 stop release", sdaOe == 1'b0, sdaOe, 0);
  endtask

  task automatic readBytes(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      getByte(k != n - 1, b);
      check(tag, b == refMem[refAddr], b, refMem[refAddr]);
      refAddr = refAddr + 9'd1;
    end
  endtask

  task automatic writeSeq(input logic [15:0] a, input int n);
    logic ack;
    logic [7:0] pend [64];
    logic [63:0] pmask;
    pmask = '0;
    busStart();
    sendByte(dev(1'b0), ack); check("R1 select ack", ack, ack, 1);
    sendByte(a[15:8], ack);   check("R3 addr hi ack", ack, ack, 1);
    sendByte(a[7:0], ack);    check("R3 addr lo ack", ack, ack, 1);
    refAddr = a[8:0];
    for (int k = 0; k < n; k++) begin
      sendByte(wdat[k], ack);
      if (wrCtlB) check("R6 data nack", !ack, ack, 0);
      else begin
        check("R4 data ack", ack, ack, 1);
        pend[refAddr[5:0]] = wdat[k];
        pmask[refAddr[5:0]] = 1'b1;
        refAddr = {refAddr[8:6], refAddr[5:0] + 6'd1};
      end
    end
    busStop(1'b1);
    for (int j = 0; j < 64; j++)
      if (pmask[j]) refMem[{refAddr[8:6], 6'(j)}] = pend[j];
  endtask

  task automatic readRandom(input logic [15:0] a, input int n, input string tag);
    logic ack;
    busStart();
    sendByte(dev(1'b0), ack); check("R1 select ack", ack, ack, 1);
    sendByte(a[15:8], ack);   check("R3 addr hi ack", ack, ack, 1);
    sendByte(a[7:0], ack);    check("R3 addr lo ack", ack, ack, 1);
    refAddr = a[8:0];
    busStart();
    sendByte(dev(1'b1), ack); check("R7 read select ack", ack, ack, 1);
    readBytes(n, tag);
    busStop(1'b1);
  endtask

  task automatic readCurrent(input int n, input string tag);
    logic ack;
    busStart();
    sendByte(dev(1'b1), ack); check("R8 read select ack", ack, ack, 1);
    readBytes(n, tag);
    busStop(1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 512; i++) refMem[i] = '0;
    repeat (5) @(negedge clk);
    check("R11 reset drive", sdaOe == 1'b0, sdaOe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 idle drive", sdaOe == 1'b0, sdaOe, 0);

    // R11/R8: current read after reset starts at address zero with zero data
    readCurrent(2, "R11 R8 reset read");

    // R1: mismatching select bytes
    busStart();
    sendByte({4'b1010, 1'b0, 2'b01, 1'b0}, ack); check("R1 chip enable mismatch", !ack, ack, 0);
    sendByte(dev(1'b0), ack); check("R1 ignored until START", !ack, ack, 0);
    busStop(1'b1);
    busStart();
    sendByte({4'b1010, 1'b1, chipEnB, 1'b0}, ack); check("R1 bit3 set", !ack, ack, 0);
    busStop(1'b1);
    busStart();
    sendByte({4'b1011, 1'b0, chipEnB, 1'b0}, ack); check("R1 type mismatch", !ack, ack, 0);
    busStop(1'b1);

    // R3/R4/R7: page write with bit 15 set, random read back
    for (int k = 0; k < 5; k++) wdat[k] = 8'h11 * (k + 1);
    writeSeq(16'h8123, 5);
    readRandom(16'h0123, 5, "R3 R7 read back");

    // R4: page wrap with overwrite
    for (int k = 0; k < 66; k++) wdat[k] = 8'(k + 8'h40);
    writeSeq(16'h017E, 66);
    readRandom(16'h0140, 64, "R4 page wrap");
    readRandom(16'h0180, 1, "R4 next page untouched");

    // R6: write control blocks data, address still loads the counter
    wdat[0] = 8'h3C; wdat[1] = 8'hC3;
    writeSeq(16'h0050, 2);
    wrCtlB = 1'b1;
    wdat[0] = 8'hAA; wdat[1] = 8'hBB; wdat[2] = 8'hCC;
    writeSeq(16'h0050, 3);
    wrCtlB = 1'b0;
    readCurrent(2, "R6 R8 blocked write");

    // R5: buffered data discarded by repeated START
    busStart();
    sendByte(dev(1'b0), ack); check("R1 select ack", ack, ack, 1);
    sendByte(8'h01, ack); sendByte(8'h23, ack);
    sendByte(8'h5A, ack); check("R5 data ack", ack, ack, 1);
    busStart();
    sendByte(dev(1'b1), ack); check("R5 read select ack", ack, ack, 1);
    refAddr = 9'h124;
    readBytes(1, "R5 counter after buffer");
    busStop(1'b1);
    readRandom(16'h0123, 1, "R5 discarded");

    // R9: sequential read across the top of the array
    wdat[0] = 8'hE1; wdat[1] = 8'hE2;
    writeSeq(16'h01FE, 2);
    wdat[0] = 8'hD1; wdat[1] = 8'hD2;
    writeSeq(16'h0000, 2);
    readRandom(16'h01FE, 4, "R9 wrap read");

    // R10: after a refused read byte SDA stays released
    busStart();
    sendByte(dev(1'b1), ack); check("R8 read select ack", ack, ack, 1);
    getByte(1'b0, b);
    check("R10 nack byte", b == refMem[refAddr], b, refMem[refAddr]);
    refAddr = refAddr + 9'd1;
    for (int k = 0; k < 9; k++) begin
      mLow = 1'b0; waitQ(); sclM = 1'b1; waitQ();
      check("R10 released", sdaLine == 1'b1, sdaLine, 1);
      sclM = 1'b0; waitQ();
    end
    busStop(1'b1);
    readCurrent(1, "R10 R8 after nack");

    // Constrained random transactions
    for (int it = 0; it < 15; it++) begin
      int op;
      int n;
      logic [15:0] a;
      op = int'($urandom % 3);
      a = 16'($urandom);
      if (op == 0) begin
        n = 1 + int'($urandom % 8);
        for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
        wrCtlB = ($urandom % 4) == 0;
        writeSeq(a, n);
        wrCtlB = 1'b0;
      end else if (op == 1) begin
        readRandom(a, 1 + int'($urandom % 4), "R7 R9 random read");
      end else begin
        readCurrent(1 + int'($urandom % 3), "R8 R9 random current");
      end
    end

    check("R2 drive changes only with SCL low", drvViol == 0, drvViol, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule